// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank-State Checker

This block watches the command pins of a DDR2 memory interface. At every rising clock edge it takes the clock-enable level, the four active-low strobes, the bank address and the address bus, and turns them into one named command. Clock-enable is read from both the previous sample and the current one. That lets the block tell normal operation apart from power-down entry, self-refresh entry and the exit from either state.

The block also keeps its own copy of each bank's state: whether the bank is idle or has a row open, and which row that is. It checks every command against that state and against two timing windows. The first window is the gap required after a mode-register load. The second is the two-cycle span of a burst of four, which must not be interrupted. The first rule broken is latched into a sticky flag together with a 3-bit reason code. The flag stays set until a clear input is pulsed. The decoded command, its bank, its address, the open row it refers to and its auto-precharge request appear on registered outputs one clock after the sample.

Top module: `ddr2_cmd_monitor`

## Requirements
- R1: While reset is asserted, the outputs read as follows: command code 0, bank, address, row and auto-precharge all zero, every bank idle, violation flag low and reason code 0. The previous clock-enable is taken as low.
- R2: With clock-enable high in both samples, the command code is decided by the pins in this order. Chip-select high gives 0 (deselect), whatever the other pins show. Otherwise the strobes {RAS#,CAS#,WE#} decide the code: 111 gives 1 (no-op), 000 gives 2 (mode load), 001 gives 3 (refresh), 010 gives 7 (precharge one bank) when A10 is low and 8 (precharge all) when A10 is high, 011 gives 9 (activate), 100 gives 10 (write), 101 gives 11 (read), and 110 gives 1.
- R3: Clock-enable low in the previous sample and high now gives code 6 (exit), whatever the other pins show. Clock-enable high then low gives one of three codes: 5 (power-down entry) with a deselect or no-op on the pins, 4 (self-refresh entry) with the refresh strobes, and 12 (clock-enable low) for any other pin state. Clock-enable low in both samples gives 12.
- R4: Every output is registered and shows the command sampled at the previous rising edge. The bank output carries BA, and the address output carries A12..A0 unchanged. The auto-precharge output equals A10 for read and write and is 0 for every other command.
- R5: A legal activate opens the addressed bank and records A12..A0 as its row. For activate, the row output shows that address. For read and write, it shows the row open in the addressed bank. A precharge-one closes only the addressed bank. A precharge-all closes every bank. No other command changes bank state.
- R6: A read or write to an idle bank is a violation with code 1. An activate to a bank that already has a row open is a violation with code 2.
- R7: A mode load while any bank is open is a violation with code 3. The bank output carries the selected mode register.
- R8: After a legal mode load, any executable command is a violation with code 4 during the next tMRD-1 rising edges, where tMRD is the value on the programming input. The executable commands are mode load, refresh, self-refresh entry, either precharge, activate, read and write. No-op, deselect, power-down entry, exit and clock-enable low are allowed in that window.
- R9: After a legal read or write, another read or write at any of the next BURST_CYC-1 rising edges is a violation with code 5. The default BURST_CYC is 2.
- R10: A legal read or write with A10 high closes its bank at the edge where its burst ends. By default that is the edge after the command.
- R11: Self-refresh entry while any bank is open is a violation with code 6.
- R12: The violation flag is sticky, and the reason code keeps the first violation seen. A clear pulse resets both. If a violation occurs in the same cycle as the clear, that violation is latched. A violating command changes neither bank state nor either timing window.
- R13: When a command breaks several rules at once, only one code is recorded. The codes are checked in this order: 4, 5, 1, 2, 3, 6, and the first that applies is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge samples |
| rst_i | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_n_i | input | 1 | Chip-select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write-enable strobe, active low |
| ba_i | input | BA_W | Bank address |
| addr_i | input | A_W | Address bus (row, column or opcode) |
| tmrd_cyc_i | input | MRD_W | Programmed mode-load gap in cycles |
| viol_clr_i | input | 1 | Synchronous clear of the sticky violation |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BA_W | Bank of the decoded command |
| addr_o | output | A_W | Address of the decoded command |
| row_o | output | A_W | Row opened, or row accessed |
| ap_o | output | 1 | Auto-precharge requested |
| bank_open_o | output | 2**BA_W | Per-bank open flags |
| viol_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 3 | Reason of the first violation |

## Verification
The bench targets the exact edges where each window closes. It issues an activate on the last forbidden edge after a mode load and again on the first allowed edge. It also issues a second read one cycle and then two cycles after a first one. A design whose counters are off by one would flag the legal case or miss the illegal one. The bench also sends a command that breaks two rules at once, then a later violation with a different reason, to confirm that only the first code is kept. It reads a bank's row after a rejected second activate: a design that applied violating commands would show the rejected row. Finally it drives every clock-enable transition, including a rise with deselect on the pins, to expose a decoder that ignores the previous sample.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_LMR   = 4'd2,
        CMD_REF   = 4'd3,
        CMD_SREF  = 4'd4,
        CMD_PDE   = 4'd5,
        CMD_EXIT  = 4'd6,
        CMD_PRE   = 4'd7,
        CMD_PREA  = 4'd8,
        CMD_ACT   = 4'd9,
        CMD_WR    = 4'd10,
        CMD_RD    = 4'd11,
        CMD_CKEL  = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE      = 3'd0,
        RSN_RDWR_IDLE = 3'd1,
        RSN_ACT_OPEN  = 3'd2,
        RSN_LMR_OPEN  = 3'd3,
        RSN_MRD       = 3'd4,
        RSN_BURST     = 3'd5,
        RSN_SREF_OPEN = 3'd6
    } rsn_e;

    function automatic logic cmd_is_exec(cmd_e c);
        return (c == CMD_LMR) || (c == CMD_REF) || (c == CMD_SREF) ||
               (c == CMD_PRE) || (c == CMD_PREA) || (c == CMD_ACT) ||
               (c == CMD_WR)  || (c == CMD_RD);
    endfunction

    function automatic logic cmd_is_rdwr(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_mon_pkg::*;
(
    input  logic cke_prev_i,
    input  logic cke_i,
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    input  logic a10_i,
    output cmd_e cmd_o
);

    logic [2:0] strobes;
    assign strobes = {ras_n_i, cas_n_i, we_n_i};

    always_comb begin
        cmd_o = CMD_CKEL;
        case ({cke_prev_i, cke_i})
            2'b01: cmd_o = CMD_EXIT;
            2'b10: begin
                if (cs_n_i || strobes == 3'b111) cmd_o = CMD_PDE;
                else if (strobes == 3'b001)      cmd_o = CMD_SREF;
                else                             cmd_o = CMD_CKEL;
            end
            2'b11: begin
                if (cs_n_i) begin
                    cmd_o = CMD_DESEL;
                end else begin
                    case (strobes)
                        3'b000:  cmd_o = CMD_LMR;
                        3'b001:  cmd_o = CMD_REF;
                        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
                        3'b011:  cmd_o = CMD_ACT;
                        3'b100:  cmd_o = CMD_WR;
                        3'b101:  cmd_o = CMD_RD;
                        default: cmd_o = CMD_NOP;
                    endcase
                end
            end
            default: cmd_o = CMD_CKEL;
        endcase
    end

endmodule

// File: rtl/ddr2_win_cnt.sv
module ddr2_win_cnt #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = load_val_i;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // Windows for R8 and R9 are only reopened once they have run out.
    assert_load_when_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> (cnt_q == '0));

endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track #(
    parameter int BA_W = 2,
    parameter int A_W  = 13
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   act_i,
    input  logic                   pre_i,
    input  logic                   prea_i,
    input  logic                   ap_close_i,
    input  logic [BA_W-1:0]        bank_i,
    input  logic [BA_W-1:0]        ap_bank_i,
    input  logic [A_W-1:0]         row_i,
    output logic [(1<<BA_W)-1:0]   open_o,
    output logic [A_W-1:0]         row_o
);

    localparam int NB = 1 << BA_W;

    typedef struct packed {
        logic [NB-1:0]          open;
        logic [NB-1:0][A_W-1:0] row;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NB; b++) begin
            if (prea_i)                                    st_d.open[b] = 1'b0;
            if (pre_i && bank_i == BA_W'(b))               st_d.open[b] = 1'b0;
            if (ap_close_i && ap_bank_i == BA_W'(b))       st_d.open[b] = 1'b0;
            if (act_i && bank_i == BA_W'(b)) begin
                st_d.open[b] = 1'b1;
                st_d.row[b]  = row_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row[bank_i];

    for (genvar gb = 0; gb < NB; gb++) begin : g_bank_chk
        assert_open_by_act_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(st_q.open[gb]) |-> $past(act_i && bank_i == BA_W'(gb)));
        assert_close_cause_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(st_q.open[gb]) |-> $past(prea_i || (pre_i && bank_i == BA_W'(gb)) ||
                                           (ap_close_i && ap_bank_i == BA_W'(gb))));
    end

endmodule

// File: rtl/ddr2_cmd_monitor.sv
module ddr2_cmd_monitor
    import ddr2_mon_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int A_W       = 13,
    parameter int MRD_W     = 4,
    parameter int BURST_CYC = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  cke_i,
    input  logic                  cs_n_i,
    input  logic                  ras_n_i,
    input  logic                  cas_n_i,
    input  logic                  we_n_i,
    input  logic [BA_W-1:0]       ba_i,
    input  logic [A_W-1:0]        addr_i,
    input  logic [MRD_W-1:0]      tmrd_cyc_i,
    input  logic                  viol_clr_i,
    output logic [3:0]            cmd_o,
    output logic [BA_W-1:0]       bank_o,
    output logic [A_W-1:0]        addr_o,
    output logic [A_W-1:0]        row_o,
    output logic                  ap_o,
    output logic [(1<<BA_W)-1:0]  bank_open_o,
    output logic                  viol_o,
    output logic [2:0]            viol_code_o
);

    localparam int NB     = 1 << BA_W;
    localparam int AP_BIT = 10;
    localparam int BW     = (BURST_CYC > 2) ? $clog2(BURST_CYC) : 1;

    typedef struct packed {
        logic             cke_prev;
        cmd_e             cmd;
        logic [BA_W-1:0]  bank;
        logic [A_W-1:0]   addr;
        logic [A_W-1:0]   row;
        logic             ap;
        logic             ap_pend;
        logic [BA_W-1:0]  ap_bank;
        logic             viol;
        rsn_e             code;
    } mon_st_t;

    mon_st_t st_d, st_q;

    cmd_e             cmd_now;
    rsn_e             rsn;
    logic             legal, rdwr, exec_cmd;
    logic [NB-1:0]    trk_open;
    logic [A_W-1:0]   trk_row;
    logic [MRD_W-1:0] mrd_cnt, mrd_val;
    logic [BW-1:0]    bst_cnt;
    logic             mrd_busy, bst_busy, bst_last, ap_close;

    ddr2_cmd_decode u_dec (
        .cke_prev_i (st_q.cke_prev),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .a10_i      (addr_i[AP_BIT]),
        .cmd_o      (cmd_now)
    );

    assign rdwr     = cmd_is_rdwr(cmd_now);
    assign exec_cmd = cmd_is_exec(cmd_now);
    assign mrd_busy = (mrd_cnt != '0);
    assign bst_busy = (bst_cnt != '0);
    assign bst_last = (bst_cnt == BW'(1));
    assign ap_close = bst_last && st_q.ap_pend;
    assign mrd_val  = (tmrd_cyc_i == '0) ? '0 : tmrd_cyc_i - 1'b1;

    // Reason selection, fixed priority (R13)
    always_comb begin
        rsn = RSN_NONE;
        if (mrd_busy && exec_cmd)                        rsn = RSN_MRD;
        else if (bst_busy && rdwr)                       rsn = RSN_BURST;
        else if (rdwr && !trk_open[ba_i])                rsn = RSN_RDWR_IDLE;
        else if (cmd_now == CMD_ACT && trk_open[ba_i])   rsn = RSN_ACT_OPEN;
        else if (cmd_now == CMD_LMR && |trk_open)        rsn = RSN_LMR_OPEN;
        else if (cmd_now == CMD_SREF && |trk_open)       rsn = RSN_SREF_OPEN;
    end

    assign legal = (rsn == RSN_NONE);

    ddr2_win_cnt #(.W(MRD_W)) u_mrd (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (legal && cmd_now == CMD_LMR),
        .load_val_i (mrd_val),
        .cnt_o      (mrd_cnt)
    );

    ddr2_win_cnt #(.W(BW)) u_bst (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (legal && rdwr),
        .load_val_i (BW'(BURST_CYC - 1)),
        .cnt_o      (bst_cnt)
    );

    ddr2_bank_track #(.BA_W(BA_W), .A_W(A_W)) u_trk (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .act_i      (legal && cmd_now == CMD_ACT),
        .pre_i      (legal && cmd_now == CMD_PRE),
        .prea_i     (legal && cmd_now == CMD_PREA),
        .ap_close_i (ap_close),
        .bank_i     (ba_i),
        .ap_bank_i  (st_q.ap_bank),
        .row_i      (addr_i),
        .open_o     (trk_open),
        .row_o      (trk_row)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cke_prev = cke_i;
        st_d.cmd      = cmd_now;
        st_d.bank     = ba_i;
        st_d.addr     = addr_i;
        st_d.ap       = rdwr && addr_i[AP_BIT];
        if (cmd_now == CMD_ACT) st_d.row = addr_i;
        else if (rdwr)          st_d.row = trk_row;
        else                    st_d.row = '0;

        if (legal && rdwr) begin
            st_d.ap_pend = addr_i[AP_BIT];
            st_d.ap_bank = ba_i;
        end else if (bst_last) begin
            st_d.ap_pend = 1'b0;
        end

        st_d.viol = st_q.viol && !viol_clr_i;
        st_d.code = viol_clr_i ? RSN_NONE : st_q.code;
        if (!legal && !st_d.viol) begin
            st_d.viol = 1'b1;
            st_d.code = rsn;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q          <= '0;
            st_q.cmd      <= CMD_DESEL;
            st_q.code     <= RSN_NONE;
        end else begin
            st_q          <= st_d;
        end
    end

    assign cmd_o       = st_q.cmd;
    assign bank_o      = st_q.bank;
    assign addr_o      = st_q.addr;
    assign row_o       = st_q.row;
    assign ap_o        = st_q.ap;
    assign bank_open_o = trk_open;
    assign viol_o      = st_q.viol;
    assign viol_code_o = st_q.code;

    assert_sticky_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.viol && !viol_clr_i) |=> (viol_o && $stable(viol_code_o)));

    assert_cke_exit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cke_i) |=> (st_q.cmd == CMD_EXIT));

    assert_burst_cut_R9: assert property (@(posedge clk_i) disable iff (rst_i || viol_clr_i)
        (cmd_is_rdwr(st_q.cmd) ##1 cmd_is_rdwr(st_q.cmd)) |-> viol_o);

    assert_code_set_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(viol_o) |-> (viol_code_o != RSN_NONE));

endmodule

// File: tb/ddr2_cmd_monitor_tb_top.sv
module ddr2_cmd_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b0, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  tmrd = 4'd3;
    logic        clr = 1'b0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o, row_o;
    logic        ap_o, viol_o;
    logic [3:0]  open_o;
    logic [2:0]  code_o;

    int checks = 0, failures = 0, cyc = 0;
    bit cke_lvl = 1'b0;

    always #10 clk = ~clk;

    ddr2_cmd_monitor dut_i (
        .clk_i(clk), .rst_i(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .tmrd_cyc_i(tmrd),
        .viol_clr_i(clr), .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .row_o(row_o),
        .ap_o(ap_o), .bank_open_o(open_o), .viol_o(viol_o), .viol_code_o(code_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model, evaluated at each rising edge
    int m_prev, m_burst, m_mrd, m_apb, m_ap;
    int m_open[4], m_row[4];
    int e_cmd, e_bank, e_addr, e_row, e_ap, e_viol, e_code;

    always @(posedge clk) begin : ref_model
        int c, rsn, rcw, anyo;
        bit rw, ex;
        cyc++;
        if (rst) begin
            m_prev = 0; m_burst = 0; m_mrd = 0; m_apb = 0; m_ap = 0;
            for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
            e_cmd = 0; e_bank = 0; e_addr = 0; e_row = 0; e_ap = 0; e_viol = 0; e_code = 0;
        end else begin
            rcw = {ras_n, cas_n, we_n};
            if (m_prev == 0 && cke) c = 6;
            else if (m_prev == 1 && !cke) c = (cs_n || rcw == 7) ? 5 : (rcw == 1 ? 4 : 12);
            else if (!cke) c = 12;
            else if (cs_n) c = 0;
            else begin
                case (rcw)
                    0: c = 2; 1: c = 3; 2: c = addr[10] ? 8 : 7; 3: c = 9;
                    4: c = 10; 5: c = 11; default: c = 1;
                endcase
            end
            rw = (c == 10 || c == 11);
            ex = (c == 2 || c == 3 || c == 4 || c == 7 || c == 8 || c == 9 || rw);
            anyo = 0;
            for (int b = 0; b < 4; b++) anyo += m_open[b];
            rsn = 0;
            if (m_mrd > 0 && ex) rsn = 4;
            else if (m_burst > 0 && rw) rsn = 5;
            else if (rw && m_open[ba] == 0) rsn = 1;
            else if (c == 9 && m_open[ba] == 1) rsn = 2;
            else if (c == 2 && anyo > 0) rsn = 3;
            else if (c == 4 && anyo > 0) rsn = 6;
            e_cmd = c; e_bank = ba; e_addr = addr; e_ap = rw ? addr[10] : 0;
            e_row = (c == 9) ? addr : (rw ? m_row[ba] : 0);
            if (m_mrd > 0) m_mrd--;
            if (m_burst == 1 && m_ap) begin m_open[m_apb] = 0; m_ap = 0; end
            if (m_burst > 0) m_burst--;
            if (rsn == 0) begin
                if (c == 9) begin m_open[ba] = 1; m_row[ba] = addr; end
                if (c == 7) m_open[ba] = 0;
                if (c == 8) for (int b = 0; b < 4; b++) m_open[b] = 0;
                if (c == 2) m_mrd = (tmrd == 0) ? 0 : tmrd - 1;
                if (rw) begin m_burst = 1; m_ap = addr[10]; m_apb = ba; end
            end
            if (clr) begin e_viol = 0; e_code = 0; end
            if (rsn != 0 && e_viol == 0) begin e_viol = 1; e_code = rsn; end
            m_prev = cke;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            chk("R2 model cmd", cmd_o, e_cmd);
            chk("R4 model bank", bank_o, e_bank);
            chk("R4 model addr", addr_o, e_addr);
            chk("R4 model ap", ap_o, e_ap);
            chk("R5 model row", row_o, e_row);
            chk("R5 model open", open_o, {m_open[3][0], m_open[2][0], m_open[1][0], m_open[0][0]});
            chk("R12 model viol", viol_o, e_viol);
            chk("R12 model code", code_o, e_code);
        end
    end

    task automatic drive(input bit ck, input bit cs, input bit r, input bit c, input bit w,
                         input int b, input int a);
        @(negedge clk);
        cke = ck; cke_lvl = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = b[1:0]; addr = a[12:0];
        @(posedge clk); #1;
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
    endtask

    task automatic nop();                         drive(cke_lvl, 0, 1, 1, 1, 0, 0);               endtask
    task automatic act(input int b, input int r); drive(1, 0, 0, 1, 1, b, r);                     endtask
    task automatic rd(input int b, input int cl, input int ap); drive(1, 0, 1, 0, 1, b, cl | (ap << 10)); endtask
    task automatic wr(input int b, input int cl, input int ap); drive(1, 0, 1, 0, 0, b, cl | (ap << 10)); endtask
    task automatic pre(input int b);              drive(1, 0, 0, 1, 0, b, 0);                     endtask
    task automatic prea();                        drive(1, 0, 0, 1, 0, 0, 1 << 10);               endtask
    task automatic lmr(input int b, input int op); drive(1, 0, 0, 0, 0, b, op);                   endtask
    task automatic clear();
        @(negedge clk); clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cmd", cmd_o, 0);
        chk("R1 open", open_o, 0);
        chk("R1 viol", viol_o, 0);
        chk("R1 code", code_o, 0);
        rst = 1'b0;
        drive(1, 0, 1, 1, 1, 0, 0);           chk("R3 exit after reset", cmd_o, 6);
        nop();                                chk("R2 nop", cmd_o, 1);
        drive(1, 1, 0, 0, 0, 0, 0);           chk("R2 deselect", cmd_o, 0);
        act(0, 'h123);                        chk("R5 act cmd", cmd_o, 9);
        chk("R5 act row", row_o, 'h123);      chk("R5 open", open_o, 4'b0001);
        nop();
        rd(0, 'h10, 0);                       chk("R4 rd addr", addr_o, 'h10);
        chk("R5 rd row", row_o, 'h123);       chk("R4 rd ap", ap_o, 0);
        nop();
        wr(0, 'h8, 1);                        chk("R4 wr ap", ap_o, 1);
        chk("R10 still open", open_o, 4'b0001);
        nop();                                chk("R10 ap closed", open_o, 4'b0000);
        chk("R10 no viol", viol_o, 0);
        rd(1, 0, 0);                          chk("R6 rd idle", code_o, 1);
        clear();                              chk("R12 clear", viol_o, 0);
        act(2, 5); act(2, 6);                 chk("R6 act open", code_o, 2);
        clear(); rd(2, 0, 0);                 chk("R12 rejected act row", row_o, 5);
        chk("R12 legal rd", viol_o, 0);
        nop();
        lmr(1, 'h42);                         chk("R7 lmr open", code_o, 3);
        chk("R7 mode reg", bank_o, 1);
        clear(); prea();                      chk("R5 prea", open_o, 0);
        act(3, 7); act(1, 8); pre(3);         chk("R5 pre one", open_o, 4'b0010);
        prea();
        lmr(0, 'h33);                         chk("R8 lmr ok", viol_o, 0);
        nop(); act(0, 1);                     chk("R8 mrd window", code_o, 4);
        clear(); act(0, 1);                   chk("R8 after window", viol_o, 0);
        prea(); lmr(0, 'h33); nop(); nop(); act(0, 1);
        chk("R8 boundary legal", viol_o, 0);
        rd(0, 0, 0); wr(0, 0, 0);             chk("R9 burst cut", code_o, 5);
        clear(); rd(0, 0, 0); nop(); rd(0, 4, 0);
        chk("R9 burst boundary", viol_o, 0);
        nop(); prea();
        lmr(2, 0); rd(3, 0, 0);               chk("R13 priority", code_o, 4);
        nop(); rd(1, 0, 0);                   chk("R12 first kept", code_o, 4);
        clear();
        act(1, 2); drive(0, 0, 0, 0, 1, 0, 0); chk("R3 sref cmd", cmd_o, 4);
        chk("R11 sref open", code_o, 6);
        nop();                                chk("R3 cke low", cmd_o, 12);
        drive(1, 1, 0, 0, 0, 0, 0);           chk("R3 exit", cmd_o, 6);
        clear(); pre(1);
        drive(0, 0, 0, 0, 1, 0, 0);           chk("R11 sref idle", viol_o, 0);
        nop();                                chk("R3 held low", cmd_o, 12);
        drive(1, 0, 1, 1, 1, 0, 0);
        drive(0, 1, 1, 1, 1, 0, 0);           chk("R3 pd entry", cmd_o, 5);
        drive(1, 0, 1, 1, 1, 0, 0);
        drive(1, 0, 1, 1, 0, 0, 0);           chk("R2 reserved", cmd_o, 1);
        drive(1, 0, 0, 0, 1, 0, 0);           chk("R2 refresh", cmd_o, 3);
        repeat (3) nop();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule